// File: doc/BRIEF.md
# Fractional-Rate Master Counter

This block keeps a 64-bit count that advances at a fixed nominal rate of 6.144 MHz, whatever reference clock drives it. It does not divide by an integer. A phase accumulator adds a programmable numerator on every reference clock. When the sum reaches the programmable denominator, the denominator is taken back off and the count moves up by one. The long-run count rate is therefore the reference frequency times numerator over denominator.

Software sets the ratio through two 32-bit registers. The ratio itself sits in the low 12 bits of each register, and the upper 20 bits are plain storage. A reference-select input names the clock that is currently feeding the block. When that input changes, the block loads the matching preset ratio by itself, so the count rate holds across the switch. The whole count is driven on an output port.

Top module: `frc_master_counter`

## Requirements
- R1: After reset the count is 0, the accumulator is 0, the numerator register reads 0x00000004 and the denominator register reads 0x00000019.
- R2: A write at offset 0x10 stores all 32 bits into the numerator register, and a write at offset 0x14 does the same for the denominator register. Both read back at their own offsets. Any other offset reads 0, and a write to it changes neither register.
- R3: On each clock, with numerator N less than denominator D, the accumulator adds N. When the sum is D or more, D is subtracted and the count rises by one. Starting from a zero accumulator, the count after k clocks is floor(k*N/D). From any accumulator value below D, 2*D clocks add exactly 2*N.
- R4: The count never rises by more than one in a single clock.
- R5: When N is D or more, including D = 0, the count rises by one on every clock and the accumulator is held at 0.
- R6: A register write takes effect on the clock edge after the edge that stores it.
- R7: On the first clock edge after ref_sel changes, the low 12 bits of both registers load the preset for the new selection, and their upper 20 bits keep their old values. The presets are: 0 gives 4/25 (38.4 MHz), 1 gives 8/25 (19.2 MHz), 2 gives 64/125 (12 MHz), 3 gives 768/1625 (13 MHz), 4 gives 384/1625 (26 MHz) and 5 gives 256/1125 (27 MHz).
- R8: The unrecognised selections 6 and 7 load the 38.4 MHz preset, 4/25.
- R9: If a register write and a ref_sel change fall on the same edge, the preset load wins and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_sel | input | 3 | Which reference clock is feeding the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read offset |
| rd_data | output | 32 | Register read data (combinational) |
| count | output | 64 | Free-running count |

## Verification
Register writes and preset loads are visible on rd_data right after the edge that takes them. That edge still runs the accumulator with the old ratio, and the new ratio first acts on the edge after it. The count register changes on the same edge as the accumulator, so the bench drives inputs and samples outputs on falling edges and counts rising edges one by one between stimulus and check. For each preset ratio, the bench measures the count gained over exactly 2*D edges. That gain does not depend on the accumulator's starting phase, so the result can be predicted without any knowledge of the accumulator's internal state.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int FRC_FIELD_W = 12;
  localparam int FRC_SEL_W   = 3;

  typedef struct packed {
    logic [FRC_FIELD_W-1:0] num;
    logic [FRC_FIELD_W-1:0] den;
  } frc_ratio_t;

  // Preset ratio per reference selection; anything unknown falls back to 38.4 MHz.
  function automatic frc_ratio_t frc_preset(input logic [FRC_SEL_W-1:0] sel);
    frc_ratio_t r;
    case (sel)
      3'd1:    begin r.num = 12'd8;   r.den = 12'd25;   end
      3'd2:    begin r.num = 12'd64;  r.den = 12'd125;  end
      3'd3:    begin r.num = 12'd768; r.den = 12'd1625; end
      3'd4:    begin r.num = 12'd384; r.den = 12'd1625; end
      3'd5:    begin r.num = 12'd256; r.den = 12'd1125; end
      default: begin r.num = 12'd4;   r.den = 12'd25;   end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/frc_ratio_regs.sv
module frc_ratio_regs
  import frc_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int FIELD_W = FRC_FIELD_W,
  parameter int ADDR_W  = 5,
  parameter int SEL_W   = FRC_SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  ref_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic [REG_W-1:0]  num_reg,
  output logic [REG_W-1:0]  den_reg,
  output logic              sel_change
);
  localparam logic [ADDR_W-1:0] NUM_OFS = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] DEN_OFS = ADDR_W'(5'h14);
  localparam int UPPER_W = REG_W - FIELD_W;

  logic [SEL_W-1:0] sel_q;
  frc_ratio_t       preset;

  assign sel_change = (ref_sel != sel_q);
  assign preset     = frc_preset(ref_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= '0;
      num_reg <= REG_W'(4);
      den_reg <= REG_W'(25);
    end else begin
      sel_q <= ref_sel;
      if (sel_change) begin
        num_reg <= {num_reg[REG_W-1 -: UPPER_W], preset.num};
        den_reg <= {den_reg[REG_W-1 -: UPPER_W], preset.den};
      end else if (wr_en) begin
        if (wr_addr == NUM_OFS) num_reg <= wr_data;
        if (wr_addr == DEN_OFS) den_reg <= wr_data;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      NUM_OFS: rd_data = num_reg;
      DEN_OFS: rd_data = den_reg;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/frc_phase_acc.sv
module frc_phase_acc #(
  parameter int FIELD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] num,
  input  logic [FIELD_W-1:0] den,
  output logic               tick,
  output logic [FIELD_W-1:0] acc
);
  localparam int SUM_W = FIELD_W + 1;

  logic [SUM_W-1:0]   sum;
  logic               fast;
  logic               wrap;
  logic [FIELD_W-1:0] acc_nxt;

  assign sum  = {1'b0, acc} + {1'b0, num};
  assign fast = (num >= den);
  assign wrap = (sum >= {1'b0, den});
  assign tick = fast | wrap;

  always_comb begin
    if (fast)      acc_nxt = '0;
    else if (wrap) acc_nxt = FIELD_W'(sum - {1'b0, den});
    else           acc_nxt = FIELD_W'(sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_nxt;
  end
endmodule

// File: rtl/frc_count.sv
module frc_count #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/frc_master_counter.sv
module frc_master_counter
  import frc_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int REG_W   = 32,
  parameter int ADDR_W  = 5,
  parameter int SEL_W   = FRC_SEL_W,
  parameter int FIELD_W = FRC_FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  ref_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic [CNT_W-1:0]  count
);
  logic [REG_W-1:0]   num_reg;
  logic [REG_W-1:0]   den_reg;
  logic               sel_change;
  logic               tick;
  logic [FIELD_W-1:0] acc;

  frc_ratio_regs #(
    .REG_W(REG_W), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .num_reg(num_reg), .den_reg(den_reg), .sel_change(sel_change)
  );

  frc_phase_acc #(.FIELD_W(FIELD_W)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .num(num_reg[FIELD_W-1:0]), .den(den_reg[FIELD_W-1:0]),
    .tick(tick), .acc(acc)
  );

  frc_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count(count)
  );
endmodule

// File: rtl/frc_master_counter_chk.sv
module frc_master_counter_chk
  import frc_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int REG_W   = 32,
  parameter int SEL_W   = FRC_SEL_W,
  parameter int FIELD_W = FRC_FIELD_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [SEL_W-1:0]   ref_sel,
  input logic [CNT_W-1:0]   count,
  input logic               tick,
  input logic               sel_change,
  input logic [REG_W-1:0]   num_reg,
  input logic [REG_W-1:0]   den_reg,
  input logic [FIELD_W-1:0] acc
);
  localparam int UPPER_W = REG_W - FIELD_W;

  assert_step_le_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == $past(count)) || (count == $past(count) + 1'b1));

  assert_tick_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (count == $past(count) + 1'b1));

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  assert_fast_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (num_reg[FIELD_W-1:0] >= den_reg[FIELD_W-1:0]) |=> (acc == '0));

  assert_preset_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change |=> (num_reg[FIELD_W-1:0] == frc_preset($past(ref_sel)).num) &&
                   (den_reg[FIELD_W-1:0] == frc_preset($past(ref_sel)).den));

  assert_upper_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_change |=> (num_reg[REG_W-1 -: UPPER_W] == $past(num_reg[REG_W-1 -: UPPER_W])) &&
                   (den_reg[REG_W-1 -: UPPER_W] == $past(den_reg[REG_W-1 -: UPPER_W])));
endmodule

bind frc_master_counter frc_master_counter_chk #(
  .CNT_W(CNT_W), .REG_W(REG_W), .SEL_W(SEL_W), .FIELD_W(FIELD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel), .count(count), .tick(tick),
  .sel_change(sel_change), .num_reg(num_reg), .den_reg(den_reg), .acc(acc)
);

// File: tb/sim_frc_master_counter.sv
module sim_frc_master_counter;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ref_sel = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [63:0] count;

  int errors = 0;
  int checks = 0;
  logic [63:0] c0;

  // {sel, numerator, denominator}, written from the preset list in the requirements
  localparam logic [26:0] VEC [8] = '{
    {3'd0, 12'd4,   12'd25},
    {3'd1, 12'd8,   12'd25},
    {3'd2, 12'd64,  12'd125},
    {3'd3, 12'd768, 12'd1625},
    {3'd4, 12'd384, 12'd1625},
    {3'd5, 12'd256, 12'd1125},
    {3'd6, 12'd4,   12'd25},
    {3'd7, 12'd4,   12'd25}
  };

  frc_master_counter u0 (
    .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .count(count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Leaves the bench at the falling edge right after reset is released.
  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; ref_sel = 3'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive at this falling edge; returns at the next falling edge (one rising edge taken).
  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rv;

    // R1 reset state
    do_reset();
    check("R1 count", count, 64'd0);
    reg_read(5'h10, rv); check("R1 num", {32'd0, rv}, 64'h4);
    reg_read(5'h14, rv); check("R1 den", {32'd0, rv}, 64'h19);

    // Table walk: preset loaded (R7/R8), then 2*D edges give 2*N counts (R3)
    for (int i = 0; i < 8; i++) begin
      logic [2:0]  vs;
      logic [11:0] vn;
      logic [11:0] vd;
      {vs, vn, vd} = VEC[i];
      do_reset();
      ref_sel = vs;
      @(negedge clk);
      reg_read(5'h10, rv); check("R7/R8 preset num", {32'd0, rv}, {52'd0, vn});
      reg_read(5'h14, rv); check("R7/R8 preset den", {32'd0, rv}, {52'd0, vd});
      c0 = count;
      repeat (2 * int'(vd)) @(negedge clk);
      check("R3 rate over 2*D", count - c0, 64'(2 * int'(vn)));
    end

    // R3 exact floor(4k/25) from reset
    do_reset();
    repeat (6) @(negedge clk);
    check("R3 k=6", count, 64'd0);
    @(negedge clk);
    check("R3 k=7", count, 64'd1);
    repeat (6) @(negedge clk);
    check("R3 k=13", count, 64'd2);

    // R6 + R5: write D=4 (N=4 -> fast mode), old ratio still used on the storing edge
    do_reset();
    reg_write(5'h14, 32'd4);
    check("R6 old ratio on storing edge", count, 64'd0);
    @(negedge clk);
    check("R6 new ratio next edge", count, 64'd1);
    repeat (10) @(negedge clk);
    check("R5 step every clock", count, 64'd11);

    // R5 with D = 0
    do_reset();
    reg_write(5'h14, 32'd0);
    repeat (5) @(negedge clk);
    check("R5 den zero", count, 64'd5);

    // R2 full-width write, bad offset ignored; R7 upper bits kept
    do_reset();
    reg_write(5'h10, 32'hABCDE003);
    reg_write(5'h14, 32'h12345019);
    reg_write(5'h18, 32'hFFFFFFFF);
    reg_read(5'h18, rv); check("R2 other offset reads 0", {32'd0, rv}, 64'd0);
    reg_read(5'h10, rv); check("R2 num stored", {32'd0, rv}, 64'hABCDE003);
    reg_read(5'h14, rv); check("R2 den stored", {32'd0, rv}, 64'h12345019);
    ref_sel = 3'd1;
    @(negedge clk);
    reg_read(5'h10, rv); check("R7 num upper kept", {32'd0, rv}, 64'hABCDE008);
    reg_read(5'h14, rv); check("R7 den upper kept", {32'd0, rv}, 64'h12345019);

    // R9 write and selection change on the same edge: preset wins
    do_reset();
    ref_sel = 3'd3;
    reg_write(5'h10, 32'h00000ABC);
    reg_read(5'h10, rv); check("R9 preset wins num", {32'd0, rv}, 64'h300);
    reg_read(5'h14, rv); check("R9 den", {32'd0, rv}, 64'h659);

    // R8 unknown selection restores 4/25 after a software change
    do_reset();
    reg_write(5'h10, 32'd7);
    ref_sel = 3'd7;
    @(negedge clk);
    reg_read(5'h10, rv); check("R8 fallback num", {32'd0, rv}, 64'd4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule